// File: doc/BRIEF.md
# Dual-Window Address Decoder and Translator

This block sits on the target side of a host bus bridge. It decides whether an incoming memory transaction address falls in one of two programmable slave windows, and if so it produces the address to present on the local bus. Each window covers a range of the upper half of the address space, given by a start and an end value. An offset is added to the upper half of any address that hits the window, so the upper half is remapped by addition and not by bit replacement. The lower half of the address passes through unchanged.

Software programs each window's start, end, offset and enable through a small register port with a combinational read-back. The lookup side takes an address with a valid strobe, a flag that marks the command as a memory access, and the memory-space enable from the bridge's command register. One clock later it reports whether a window was hit, which window it was, and the translated address. Bus handshaking and data movement are handled elsewhere.

Top module: `win_xlate`

## Requirements
- R1: After reset every window register reads back 0, every window is disabled, and `hit`, `hitWin` and `xlatAddr` are 0.
- R2: `regSel[2]` selects the window (0 = first window, 1 = second window). `regSel[1:0]` selects the field: 0 = start, 1 = end, 2 = offset, 3 = control. A write with `regWrEn` high stores `regWrData` on the clock edge. `regRdData` returns the selected field in the same cycle, and a stored value applies from the next lookup onward.
- R3: In a control register only bit 0 is stored, and it is the window enable. Bits 15:1 of a control read are always 0, whatever value was written.
- R4: A window whose enable bit is 0 never produces a hit, even when the address falls within its range.
- R5: A hit is reported only for a lookup in which `addrValid`, `isMemCmd` and `memSpaceEn` are all 1.
- R6: A window matches when `addr[31:16]` is greater than or equal to its start and less than or equal to its end. Both ends of the range are inclusive. A window whose start is greater than its end never matches.
- R7: On a hit, `xlatAddr[31:16]` equals `addr[31:16]` plus the offset of the hit window, taken modulo 2^16, and `xlatAddr[15:0]` equals `addr[15:0]`.
- R8: When both windows match, the first window wins and `hitWin` is 0. A hit in the second window alone gives `hitWin` = 1.
- R9: `hit`, `hitWin` and `xlatAddr` are registered and reflect the lookup presented in the previous cycle. When `hit` is 0, `hitWin` and `xlatAddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for the window registers |
| regSel | input | 3 | Register select: bit 2 selects the window, bits 1:0 select the field |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for the selected register |
| addrValid | input | 1 | A lookup address is presented this cycle |
| addr | input | 32 | Transaction address |
| isMemCmd | input | 1 | The transaction is a memory-space command |
| memSpaceEn | input | 1 | Memory-space enable from the command register |
| hit | output | 1 | A window was hit by the previous lookup |
| hitWin | output | 1 | Index of the hit window |
| xlatAddr | output | 32 | Translated local-bus address |

## Verification
The main sweep walks every one of the 65536 upper-address values with both windows enabled. The two windows overlap, and the second window reaches the top of the address space with an offset that wraps. This single pass separates inclusive from exclusive bounds, first-window priority from second-window priority, and a modular sum from a truncated or saturated one. A second sweep covers a window whose start equals its end and a window whose start is greater than its end, which shows an exact-equality compare and an inverted range. Further lookups clear each qualifier and each enable one at a time, which shows that every gating term is used on its own. The low half of the address carries a pattern that changes with the upper value, so a lower half that does not pass through straight is caught.

// File: rtl/wx_pkg.sv
package wx_pkg;

  // number of windows and width of a window index
  localparam int WX_NUM_WIN   = 2;
  localparam int WX_WIN_IDX_W = 1;

  // field selected by the low bits of the register select
  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_OFFSET = 2'd2,
    FLD_CTRL   = 2'd3
  } fieldSel_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic                    wr;      // register write this cycle
    logic [WX_WIN_IDX_W-1:0] win;     // addressed window
    fieldSel_e               fld;     // addressed field
    logic                    lookup;  // qualified memory lookup this cycle
  } wxStrobe_t;

endpackage

// File: rtl/wx_ctrl.sv
module wx_ctrl
  import wx_pkg::*;
(
  input  logic                    regWrEn,
  input  logic [WX_WIN_IDX_W+1:0] regSel,
  input  logic                    addrValid,
  input  logic                    isMemCmd,
  input  logic                    memSpaceEn,
  output wxStrobe_t               strb
);

  localparam int FLD_W = 2;

  fieldSel_e fldDec;

  always_comb begin
    unique case (regSel[FLD_W-1:0])
      2'd0:    fldDec = FLD_START;
      2'd1:    fldDec = FLD_END;
      2'd2:    fldDec = FLD_OFFSET;
      default: fldDec = FLD_CTRL;
    endcase
  end

  always_comb begin
    strb.wr     = regWrEn;
    strb.win    = regSel[FLD_W +: WX_WIN_IDX_W];
    strb.fld    = fldDec;
    // a lookup counts only for an enabled memory-space access
    strb.lookup = addrValid & isMemCmd & memSpaceEn;
  end

endmodule

// File: rtl/wx_datapath.sv
module wx_datapath
  import wx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HI_W    = 16,
  parameter int NUM_WIN = WX_NUM_WIN
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wxStrobe_t               strb,
  input  logic [HI_W-1:0]         regWrData,
  output logic [HI_W-1:0]         regRdData,
  input  logic [ADDR_W-1:0]       addr,
  output logic                    hitQ,
  output logic [WX_WIN_IDX_W-1:0] winQ,
  output logic [ADDR_W-1:0]       xlatQ
);

  localparam int LO_W = ADDR_W - HI_W;

  logic [HI_W-1:0] startQ [NUM_WIN];
  logic [HI_W-1:0] endQ   [NUM_WIN];
  logic [HI_W-1:0] offQ   [NUM_WIN];
  logic [NUM_WIN-1:0] enQ;

  logic [NUM_WIN-1:0] matchW;
  logic [HI_W-1:0]    sumW [NUM_WIN];

  logic [HI_W-1:0] addrHi;
  logic [LO_W-1:0] addrLo;

  assign addrHi = addr[ADDR_W-1:LO_W];
  assign addrLo = addr[LO_W-1:0];

  // per-window registers, comparators and adders
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic selThis;
    assign selThis = strb.wr && (int'(strb.win) == gi);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startQ[gi] <= '0;
        endQ[gi]   <= '0;
        offQ[gi]   <= '0;
        enQ[gi]    <= 1'b0;
      end else if (selThis) begin
        unique case (strb.fld)
          FLD_START:  startQ[gi] <= regWrData;
          FLD_END:    endQ[gi]   <= regWrData;
          FLD_OFFSET: offQ[gi]   <= regWrData;
          default:    enQ[gi]    <= regWrData[0];
        endcase
      end
    end

    assign matchW[gi] = enQ[gi] && (addrHi >= startQ[gi]) && (addrHi <= endQ[gi]);
    assign sumW[gi]   = addrHi + offQ[gi];

    AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
      (hitQ && winQ == WX_WIN_IDX_W'(gi)) |-> $past(enQ[gi])); // R4
    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      (hitQ && winQ == WX_WIN_IDX_W'(gi)) |->
        $past((addrHi >= startQ[gi]) && (addrHi <= endQ[gi]))); // R6
    AST_WIN_SUM: assert property (@(posedge clk) disable iff (!rstN)
      (hitQ && winQ == WX_WIN_IDX_W'(gi)) |->
        ((xlatQ[ADDR_W-1:LO_W] - $past(offQ[gi])) == $past(addrHi))); // R7
    if (gi > 0) begin : g_prio
      AST_WIN_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
        (hitQ && winQ == WX_WIN_IDX_W'(gi)) |-> ($past(matchW[gi-1:0]) == '0)); // R8
    end
  end

  // lowest index wins
  logic                    anyMatch;
  logic [WX_WIN_IDX_W-1:0] selIdx;

  always_comb begin
    anyMatch = 1'b0;
    selIdx   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (matchW[i]) begin
        anyMatch = 1'b1;
        selIdx   = WX_WIN_IDX_W'(i);
      end
    end
  end

  // registered lookup result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ  <= 1'b0;
      winQ  <= '0;
      xlatQ <= '0;
    end else if (strb.lookup && anyMatch) begin
      hitQ  <= 1'b1;
      winQ  <= selIdx;
      xlatQ <= {sumW[selIdx], addrLo};
    end else begin
      hitQ  <= 1'b0;
      winQ  <= '0;
      xlatQ <= '0;
    end
  end

  // register read-back
  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (int'(strb.win) == i) begin
        unique case (strb.fld)
          FLD_START:  regRdData = startQ[i];
          FLD_END:    regRdData = endQ[i];
          FLD_OFFSET: regRdData = offQ[i];
          default:    regRdData = {{(HI_W-1){1'b0}}, enQ[i]};
        endcase
      end
    end
  end

  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> $past(strb.lookup)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> (winQ == '0 && xlatQ == '0)); // R9
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> (xlatQ[LO_W-1:0] == $past(addrLo))); // R7
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fld == FLD_CTRL) |-> (regRdData[HI_W-1:1] == '0)); // R3

endmodule

// File: rtl/win_xlate.sv
module win_xlate
  import wx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HI_W    = 16,
  parameter int NUM_WIN = WX_NUM_WIN
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [WX_WIN_IDX_W+1:0] regSel,
  input  logic [HI_W-1:0]         regWrData,
  output logic [HI_W-1:0]         regRdData,
  input  logic                    addrValid,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    isMemCmd,
  input  logic                    memSpaceEn,
  output logic                    hit,
  output logic [WX_WIN_IDX_W-1:0] hitWin,
  output logic [ADDR_W-1:0]       xlatAddr
);

  wxStrobe_t strb;

  wx_ctrl u_ctrl (
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .addrValid  (addrValid),
    .isMemCmd   (isMemCmd),
    .memSpaceEn (memSpaceEn),
    .strb       (strb)
  );

  wx_datapath #(
    .ADDR_W  (ADDR_W),
    .HI_W    (HI_W),
    .NUM_WIN (NUM_WIN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .addr      (addr),
    .hitQ      (hit),
    .winQ      (hitWin),
    .xlatQ     (xlatAddr)
  );

endmodule

// File: tb/win_xlate_bench.sv
`timescale 1ns/1ps
module win_xlate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic        isMemCmd = 1'b0;
  logic        memSpaceEn = 1'b0;
  logic        hit;
  logic [0:0]  hitWin;
  logic [31:0] xlatAddr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // model of programmed windows, kept from the requirements
  logic [15:0] mStart [2];
  logic [15:0] mEnd   [2];
  logic [15:0] mOff   [2];
  logic        mEn    [2];

  always #2.5 clk = ~clk;

  win_xlate u_win_xlate (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .addrValid(addrValid),
    .addr(addr), .isMemCmd(isMemCmd), .memSpaceEn(memSpaceEn),
    .hit(hit), .hitWin(hitWin), .xlatAddr(xlatAddr)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 180000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<180000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int w, input int f, input logic [15:0] d);
    @(negedge clk);
    regSel = {w[0], f[1:0]};
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    case (f)
      0: mStart[w] = d;
      1: mEnd[w]   = d;
      2: mOff[w]   = d;
      default: mEn[w] = d[0];
    endcase
  endtask

  task automatic rdReg(input int w, input int f, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regSel = {w[0], f[1:0]};
    #1;
    chk(regRdData === exp, tag, 64'(regRdData), 64'(exp));
  endtask

  task automatic look(input logic [31:0] a, input bit v, input bit m, input bit se, input string tag);
    bit          eHit;
    logic [0:0]  eWin;
    logic [31:0] eAddr;
    eHit = 1'b0; eWin = '0; eAddr = '0;
    if (v && m && se) begin
      for (int i = 1; i >= 0; i--) begin
        if (mEn[i] && a[31:16] >= mStart[i] && a[31:16] <= mEnd[i]) begin
          eHit = 1'b1;
          eWin = i[0:0];
          eAddr = {16'(a[31:16] + mOff[i]), a[15:0]};
        end
      end
    end
    @(negedge clk);
    addr = a; addrValid = v; isMemCmd = m; memSpaceEn = se;
    @(negedge clk);
    chk({hit, hitWin, xlatAddr} === {eHit, eWin, eAddr}, tag,
        64'({hit, hitWin, xlatAddr}), 64'({eHit, eWin, eAddr}));
    addrValid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      mStart[i] = '0; mEnd[i] = '0; mOff[i] = '0; mEn[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs during and after reset
    chk({hit, hitWin, xlatAddr} === '0, "R1 outputs in reset", 64'({hit, hitWin, xlatAddr}), 64'h0);
    rstN = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 4; f++)
        rdReg(w, f, 16'h0000, "R1 register reset value");
    look(32'h0000_1234, 1, 1, 1, "R1 R4 no hit after reset");

    // R2 read-back of every field, R3 control masking
    wrReg(0, 0, 16'h1000); wrReg(0, 1, 16'h1FFF); wrReg(0, 2, 16'h2345);
    wrReg(1, 0, 16'h1800); wrReg(1, 1, 16'hFFFF); wrReg(1, 2, 16'hF000);
    rdReg(0, 0, 16'h1000, "R2 start0"); rdReg(0, 1, 16'h1FFF, "R2 end0");
    rdReg(0, 2, 16'h2345, "R2 off0");   rdReg(1, 0, 16'h1800, "R2 start1");
    rdReg(1, 1, 16'hFFFF, "R2 end1");   rdReg(1, 2, 16'hF000, "R2 off1");
    wrReg(0, 3, 16'hFFFE);
    rdReg(0, 3, 16'h0000, "R3 ctrl write FFFE");

    // R4: disabled windows ignore in-range addresses
    look(32'h1000_0000, 1, 1, 1, "R4 disabled window0");
    look(32'h1800_0001, 1, 1, 1, "R4 disabled both");
    look(32'hFFFF_0002, 1, 1, 1, "R4 disabled window1");

    wrReg(0, 3, 16'hFFFF);
    wrReg(1, 3, 16'h8001);
    rdReg(0, 3, 16'h0001, "R3 ctrl write FFFF");
    rdReg(1, 3, 16'h0001, "R3 ctrl write 8001");

    // R5: each qualifier alone blocks a hit
    look(32'h1234_5678, 0, 1, 1, "R5 addrValid low");
    look(32'h1234_5678, 1, 0, 1, "R5 isMemCmd low");
    look(32'h1234_5678, 1, 1, 0, "R5 memSpaceEn low");
    look(32'h1234_5678, 1, 1, 1, "R5 R8 all qualifiers");

    // exhaustive sweep of the upper half: R6 bounds, R7 sum wrap, R8 priority, R9 latency
    for (int a = 0; a < 65536; a++)
      look({16'(a), 16'(a * 37) ^ 16'h5A5A}, 1, 1, 1, "R6 R7 R8 R9 sweep A");

    // R4: window0 off again, overlap now goes to window1
    wrReg(0, 3, 16'h0000);
    look(32'h1900_0000, 1, 1, 1, "R4 R8 window0 disabled in overlap");

    // single-value window and inverted window
    wrReg(0, 0, 16'h8000); wrReg(0, 1, 16'h8000); wrReg(0, 2, 16'h0000); wrReg(0, 3, 16'h0001);
    wrReg(1, 0, 16'h9000); wrReg(1, 1, 16'h8FFF); wrReg(1, 2, 16'h0100);
    for (int a = 16'h7FF0; a <= 16'h9010; a++)
      look({16'(a), 16'(a) ^ 16'hC3C3}, 1, 1, 1, "R6 R7 sweep B");

    summary();
    $finish;
  end

endmodule